// File: doc/BRIEF.md
# Conditional Branch and Jump Unit

This unit decides, for each issued instruction, whether a conditional program-counter-relative branch or a conditional register-indirect jump is taken. A 5-bit condition field in the instruction is tested against the zero, carry and negative flags. A relative branch adds a sign-extended, doubled 5-bit offset to the address of the next instruction. A register jump takes a full 32-bit register value as its target.

When a transfer is taken, the unit captures the target and waits for exactly one more instruction to issue, which is the delay-slot instruction. It then holds the pipeline for a fixed number of wait cycles and gives a one-cycle strobe that loads the program counter with the captured target. A transfer that is not taken, and any other opcode, leaves the instruction stream alone. Instruction fetch, the register file and the flag logic sit outside the block. The flags, the branch address and the register read value arrive as plain inputs.

Top module: `branchUnit`

## Requirements
- R1: `flags` carries zero in bit 0, carry in bit 1 and negative in bit 2. Condition bit 0 set passes only with zero clear, and condition bit 1 set passes only with zero set.
- R2: Condition bits 2 and 3 test a chosen flag: bit 2 set needs it clear, and bit 3 set needs it set. Condition bit 4 chooses that flag: carry when 0, negative when 1. The condition field is `instr[4:0]`.
- R3: A transfer is taken only when every enabled test passes. Condition code 0 always passes.
- R4: For a relative branch (opcode `instr[15:10]` = 0x30), the target is `pc` + 2 + 2 × (the signed 5-bit offset in `instr[9:5]`), taken modulo 2^32. `pc` is the address of the branch instruction itself.
- R5: For a register jump (opcode 0x31), the target is `regValue` exactly as sampled with the jump.
- R6: A transfer taken at issue raises `taken` for one cycle, starting on the cycle after issue. `delaySlot` rises at the same time and stays high, through any number of cycles, until the next instruction issues.
- R7: After the delay-slot instruction issues, `stall` is high for exactly 3 cycles. In the following cycle `loadPc` is high for one cycle with `targetPc` equal to the captured target. `targetPc` does not change from capture to load.
- R8: A transfer that is not taken gives no `taken`, `delaySlot`, `stall` or `loadPc`. The unit accepts the next instruction on the very next cycle.
- R9: Opcodes other than 0x30 and 0x31 have no effect. So does any instruction issued while a taken transfer is still in progress; this includes a transfer placed in the delay slot.
- R10: During and right after reset, `taken`, `delaySlot`, `stall` and `loadPc` are low and `targetPc` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | An instruction issues this cycle |
| instr | input | 16 | Issued instruction word |
| flags | input | 3 | Packed flags {negative, carry, zero} |
| pc | input | 32 | Address of the issued instruction |
| regValue | input | 32 | Register read value for the field in bits 9:5 |
| taken | output | 1 | One-cycle pulse: transfer taken |
| delaySlot | output | 1 | Waiting for the delay-slot instruction |
| stall | output | 1 | Wait cycles after the delay slot |
| loadPc | output | 1 | Load the program counter with targetPc |
| targetPc | output | 32 | Captured transfer target |

## Verification
Results follow a fixed schedule from the clock edge that samples the issued transfer. `taken`, `delaySlot` and `targetPc` are due one edge later. `stall` is due on the three edges after the edge that takes the delay-slot instruction, and `loadPc` on the fourth. Inputs are driven on the falling edge, and each expected value is compared at the falling edge just after the edge where that result is due. The bench sweeps all 32 condition codes against all 8 flag combinations for both transfer kinds. It walks all 32 offsets and includes address wrap cases. It also holds the delay slot open for several cycles and places a transfer in the delay slot.

// File: rtl/branchUnitPkg.sv
package branchUnitPkg;

  localparam int FLAG_W = 3;
  localparam int FLAG_Z = 0;
  localparam int FLAG_C = 1;
  localparam int FLAG_N = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SLOT = 2'd1,
    ST_WAIT = 2'd2,
    ST_LOAD = 2'd3
  } xferState_t;

  typedef struct packed {
    logic capture;
    logic selJump;
  } xferStrobe_t;

endpackage

// File: rtl/branchCondEval.sv
module branchCondEval
  import branchUnitPkg::*;
#(
  parameter int CC_W = 5
) (
  input  logic [CC_W-1:0]   cond,
  input  logic [FLAG_W-1:0] flags,
  output logic              condPass
);

  localparam int SEL_BIT = CC_W - 1;

  logic zeroFlag;
  logic pickFlag;
  logic [3:0] testFail;

  assign zeroFlag = flags[FLAG_Z];

  // Bit 4 routes carry or negative into the pair of tests on bits 2/3.
  assign pickFlag = cond[SEL_BIT] ? flags[FLAG_N] : flags[FLAG_C];

  // Even bits need their flag clear; odd bits need it set.
  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : gTest
      logic tested;
      if (g < 2) begin : gZero
        assign tested = zeroFlag;
      end else begin : gPick
        assign tested = pickFlag;
      end
      if ((g % 2) == 0) begin : gClr
        assign testFail[g] = cond[g] & tested;
      end else begin : gSet
        assign testFail[g] = cond[g] & ~tested;
      end
    end
  endgenerate

  assign condPass = ~|testFail;

endmodule

// File: rtl/branchDatapath.sv
module branchDatapath
  import branchUnitPkg::*;
#(
  parameter int PC_W        = 32,
  parameter int OFF_W       = 5,
  parameter int INSTR_BYTES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStrobe_t       strobe,
  input  logic [OFF_W-1:0]  offField,
  input  logic [PC_W-1:0]   pc,
  input  logic [PC_W-1:0]   regValue,
  output logic [PC_W-1:0]   targetPc
);

  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] offScaled;
  logic [PC_W-1:0] relTarget;
  logic [PC_W-1:0] nextTarget;

  // Sign-extend, then scale by the instruction size in halfwords (x2).
  assign offScaled  = {{EXT_W{offField[OFF_W-1]}}, offField} << 1;
  assign relTarget  = pc + PC_W'(INSTR_BYTES) + offScaled;
  assign nextTarget = strobe.selJump ? regValue : relTarget;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      targetPc <= '0;
    end else if (strobe.capture) begin
      targetPc <= nextTarget;
    end
  end

endmodule

// File: rtl/branchControl.sv
module branchControl
  import branchUnitPkg::*;
#(
  parameter int         OPC_W       = 6,
  parameter logic [5:0] OP_BRANCH   = 6'h30,
  parameter logic [5:0] OP_JUMP     = 6'h31,
  parameter int         WAIT_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic [OPC_W-1:0] opcode,
  input  logic             condPass,
  output xferStrobe_t      strobe,
  output logic             taken,
  output logic             delaySlot,
  output logic             stall,
  output logic             loadPc
);

  localparam int CNT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYCLES - 1);

  xferState_t state, stateNext;
  logic [CNT_W-1:0] waitCnt, waitCntNext;
  logic isBranch, isJump, fire;

  assign isBranch = (opcode == OPC_W'(OP_BRANCH));
  assign isJump   = (opcode == OPC_W'(OP_JUMP));

  // Only an idle unit decodes; anything issued mid-transfer is ignored.
  assign fire = (state == ST_IDLE) && issueValid && (isBranch || isJump) && condPass;

  assign strobe.capture = fire;
  assign strobe.selJump = isJump;

  always_comb begin
    stateNext   = state;
    waitCntNext = waitCnt;
    unique case (state)
      ST_IDLE: begin
        if (fire) stateNext = ST_SLOT;
      end
      ST_SLOT: begin
        if (issueValid) begin
          stateNext   = ST_WAIT;
          waitCntNext = '0;
        end
      end
      ST_WAIT: begin
        if (waitCnt == CNT_LAST) begin
          stateNext = ST_LOAD;
        end else begin
          waitCntNext = waitCnt + 1'b1;
        end
      end
      ST_LOAD: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      taken   <= 1'b0;
    end else begin
      state   <= stateNext;
      waitCnt <= waitCntNext;
      taken   <= fire;
    end
  end

  assign delaySlot = (state == ST_SLOT);
  assign stall     = (state == ST_WAIT);
  assign loadPc    = (state == ST_LOAD);

endmodule

// File: rtl/branchUnit.sv
module branchUnit
  import branchUnitPkg::*;
#(
  parameter int         INSTR_W     = 16,
  parameter int         PC_W        = 32,
  parameter int         CC_W        = 5,
  parameter int         OFF_W       = 5,
  parameter int         OPC_W       = 6,
  parameter int         INSTR_BYTES = 2,
  parameter logic [5:0] OP_BRANCH   = 6'h30,
  parameter logic [5:0] OP_JUMP     = 6'h31,
  parameter int         WAIT_CYCLES = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [FLAG_W-1:0]  flags,
  input  logic [PC_W-1:0]    pc,
  input  logic [PC_W-1:0]    regValue,
  output logic               taken,
  output logic               delaySlot,
  output logic               stall,
  output logic               loadPc,
  output logic [PC_W-1:0]    targetPc
);

  localparam int OFF_LSB = CC_W;
  localparam int OPC_LSB = INSTR_W - OPC_W;

  logic [CC_W-1:0]  condField;
  logic [OFF_W-1:0] offField;
  logic [OPC_W-1:0] opcode;
  logic             condPass;
  xferStrobe_t      strobe;

  assign condField = instr[CC_W-1:0];
  assign offField  = instr[OFF_LSB +: OFF_W];
  assign opcode    = instr[OPC_LSB +: OPC_W];

  branchCondEval #(.CC_W(CC_W)) u_cond (
    .cond     (condField),
    .flags    (flags),
    .condPass (condPass)
  );

  branchControl #(
    .OPC_W       (OPC_W),
    .OP_BRANCH   (OP_BRANCH),
    .OP_JUMP     (OP_JUMP),
    .WAIT_CYCLES (WAIT_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .opcode     (opcode),
    .condPass   (condPass),
    .strobe     (strobe),
    .taken      (taken),
    .delaySlot  (delaySlot),
    .stall      (stall),
    .loadPc     (loadPc)
  );

  branchDatapath #(
    .PC_W        (PC_W),
    .OFF_W       (OFF_W),
    .INSTR_BYTES (INSTR_BYTES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .offField (offField),
    .pc       (pc),
    .regValue (regValue),
    .targetPc (targetPc)
  );

endmodule

// File: rtl/branchUnitChk.sv
module branchUnitChk
  import branchUnitPkg::*;
#(
  parameter int         INSTR_W     = 16,
  parameter int         PC_W        = 32,
  parameter int         OPC_W       = 6,
  parameter logic [5:0] OP_BRANCH   = 6'h30,
  parameter logic [5:0] OP_JUMP     = 6'h31,
  parameter int         WAIT_CYCLES = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               issueValid,
  input logic [INSTR_W-1:0] instr,
  input logic [FLAG_W-1:0]  flags,
  input logic [PC_W-1:0]    pc,
  input logic [PC_W-1:0]    regValue,
  input logic               taken,
  input logic               delaySlot,
  input logic               stall,
  input logic               loadPc,
  input logic [PC_W-1:0]    targetPc
);

  logic idle, isXfer;
  logic [31:0] stallRun;

  assign idle   = !delaySlot && !stall && !loadPc;
  assign isXfer = (instr[INSTR_W-1 -: OPC_W] == OPC_W'(OP_BRANCH)) ||
                  (instr[INSTR_W-1 -: OPC_W] == OPC_W'(OP_JUMP));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stallRun <= '0;
    else       stallRun <= stall ? stallRun + 1 : '0;
  end

  a_r3_uncond_taken: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && idle && isXfer && instr[4:0] == 5'd0) |=> taken);

  a_r6_taken_pulse: assert property (@(posedge clk) disable iff (!rstN)
    taken |=> !taken);

  a_r6_taken_in_slot: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> delaySlot);

  a_r7_stall_bound: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (stallRun < WAIT_CYCLES));

  a_r7_load_after_stall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stall) |-> loadPc);

  a_r7_load_preceded: assert property (@(posedge clk) disable iff (!rstN)
    loadPc |-> $past(stall));

  a_r7_target_stable: assert property (@(posedge clk) disable iff (!rstN)
    (stall || loadPc) |-> $stable(targetPc));

  a_r9_other_opcode: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && idle && !isXfer) |=> (!taken && !delaySlot));

  a_r8_phases_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({delaySlot, stall, loadPc}));

endmodule

bind branchUnit branchUnitChk #(
  .INSTR_W     (INSTR_W),
  .PC_W        (PC_W),
  .OPC_W       (OPC_W),
  .OP_BRANCH   (OP_BRANCH),
  .OP_JUMP     (OP_JUMP),
  .WAIT_CYCLES (WAIT_CYCLES)
) u_chk (.*);

// File: tb/branchUnit_tb.sv
module branchUnit_tb;

  localparam logic [5:0] OPB = 6'h30;
  localparam logic [5:0] OPJ = 6'h31;
  localparam logic [5:0] OPX = 6'h05;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [15:0] instr = '0;
  logic [2:0]  flags = '0;
  logic [31:0] pc = '0;
  logic [31:0] regValue = '0;
  logic        taken, delaySlot, stall, loadPc;
  logic [31:0] targetPc;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  branchUnit u_dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .instr(instr),
    .flags(flags), .pc(pc), .regValue(regValue), .taken(taken),
    .delaySlot(delaySlot), .stall(stall), .loadPc(loadPc), .targetPc(targetPc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // Condition rule from R1-style field meanings, evaluated per bit.
  function automatic logic condOk(input logic [4:0] cc, input logic [2:0] f);
    logic z, sel;
    z   = f[0];
    sel = cc[4] ? f[2] : f[1];
    condOk = 1'b1;
    if (cc[0] &&  z)   condOk = 1'b0;
    if (cc[1] && !z)   condOk = 1'b0;
    if (cc[2] &&  sel) condOk = 1'b0;
    if (cc[3] && !sel) condOk = 1'b0;
  endfunction

  task automatic xfer(input logic isJump, input logic [2:0] f, input logic [4:0] cc,
                      input logic [4:0] off, input logic [31:0] pcv, input logic [31:0] rv,
                      input logic slotXfer, input int slotHold);
    logic expTaken;
    logic [31:0] expT;
    expTaken = condOk(cc, f);
    expT = isJump ? rv : (pcv + 32'd2 + ({{27{off[4]}}, off} << 1));
    issueValid = 1'b1;
    instr = {isJump ? OPJ : OPB, off, cc};
    flags = f; pc = pcv; regValue = rv;
    @(negedge clk);
    chk(isJump ? "R5/R3 taken" : "R4/R1/R2 taken", 32'(taken), 32'(expTaken));
    if (expTaken) begin
      chk("R6 delaySlot", 32'(delaySlot), 32'd1);
      chk(isJump ? "R5 target" : "R4 target", targetPc, expT);
      issueValid = 1'b0;
      pc = ~pcv; regValue = ~rv;
      for (int h = 0; h < slotHold; h++) begin
        @(negedge clk);
        chk("R6 slot held", 32'(delaySlot), 32'd1);
        chk("R6 taken one cycle", 32'(taken), 32'd0);
      end
      issueValid = 1'b1;
      instr = slotXfer ? {OPB, 5'd3, 5'd0} : {OPX, 5'd1, 5'd0};
      @(negedge clk);
      issueValid = 1'b0;
      instr = {OPB, 5'd7, 5'd0};
      chk("R6 taken one cycle", 32'(taken), 32'd0);
      for (int w = 0; w < 3; w++) begin
        if (w > 0) @(negedge clk);
        chk("R7 stall", 32'(stall), 32'd1);
        chk("R7 no early load", 32'(loadPc), 32'd0);
      end
      @(negedge clk);
      chk("R7 stall ends", 32'(stall), 32'd0);
      chk("R7 loadPc", 32'(loadPc), 32'd1);
      chk("R7 target held", targetPc, expT);
      @(negedge clk);
      chk("R9 single transfer", 32'({taken, delaySlot, stall, loadPc}), 32'd0);
    end else begin
      issueValid = 1'b0;
      chk("R8 no slot", 32'(delaySlot), 32'd0);
      chk("R8 no stall", 32'(stall), 32'd0);
      @(negedge clk);
      chk("R8 no load", 32'({taken, delaySlot, stall, loadPc}), 32'd0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", 32'({taken, delaySlot, stall, loadPc}), 32'd0);
    chk("R10 reset target", targetPc, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 after reset", 32'({taken, delaySlot, stall, loadPc}), 32'd0);

    // Exhaustive condition x flags sweep for both transfer kinds.
    for (int k = 0; k < 2; k++) begin
      for (int fv = 0; fv < 8; fv++) begin
        for (int c = 0; c < 32; c++) begin
          logic [4:0] off;
          logic [31:0] pcv;
          off = 5'((c * 7 + fv) % 32);
          pcv = 32'(c * 32'h0101_0034) ^ 32'(fv << 28);
          xfer(k[0], 3'(fv), 5'(c), off, pcv, 32'hA5A5_0000 ^ 32'(c * 977 + fv),
               (c % 5) == 0, 0);
        end
      end
    end

    // R4 wrap cases.
    xfer(1'b0, 3'd0, 5'd0, 5'd15, 32'hFFFF_FFFE, 32'd0, 1'b0, 0);
    xfer(1'b0, 3'd0, 5'd0, 5'b10000, 32'h0000_0000, 32'd0, 1'b0, 0);
    // R6 slot held open for several cycles.
    xfer(1'b1, 3'd7, 5'd0, 5'd2, 32'h100, 32'hDEAD_BEEC, 1'b1, 4);

    // R9 non-transfer opcodes have no effect.
    for (int op = 0; op < 64; op++) begin
      if (6'(op) != OPB && 6'(op) != OPJ) begin
        issueValid = 1'b1;
        instr = {6'(op), 5'd9, 5'd0};
        @(negedge clk);
        issueValid = 1'b0;
        chk("R9 other opcode", 32'({taken, delaySlot}), 32'd0);
        chk("R9 target unchanged", targetPc, 32'hDEAD_BEEC);
      end
    end

    // R8 back-to-back: not-taken then next cycle taken.
    issueValid = 1'b1;
    instr = {OPB, 5'd1, 5'd2};
    flags = 3'b000; pc = 32'h40;
    @(negedge clk);
    chk("R8 not taken", 32'(taken), 32'd0);
    instr = {OPB, 5'd1, 5'd0};
    @(negedge clk);
    issueValid = 1'b0;
    chk("R8 next accepted", 32'(taken), 32'd1);
    chk("R8 next target", targetPc, 32'h44);
    issueValid = 1'b1;
    instr = {OPX, 10'd0};
    @(negedge clk);
    issueValid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 idle again", 32'({taken, delaySlot, stall, loadPc}), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule